// File: doc/BRIEF.md
# Programmable Clock Divider Chain

This block turns one master clock into two slower clocks. The reference side can pass the master clock through unchanged, or divide it by a power of two (1, 2, 4 or 8). The main side divides the master clock by a power of two, then optionally by an integer in the range 2 to 1025. The integer stage can be skipped with a control bit.

Both outputs keep an exact 50% duty cycle at every setting, odd overall ratios included. This is done by stretching the high phase by half a master cycle on the falling master edge. A changed setting takes effect only when the running period ends, so an output never shows a shortened or merged pulse.

The settings are plain inputs in the master clock domain. They are normally held static and are changed now and then by surrounding logic.

Top module: `pcd_clock_chain`

## Requirements
- R1: With `ref_from_pre`=1, the reference output period is 2^`ref_pre_code` master cycles (code 0→1, 1→2, 2→4, 3→8).
- R2: With `ref_from_pre`=0, the reference output is the master clock, whatever `ref_pre_code` holds.
- R3: With `main_div_skip`=0, the main output period is 2^`main_pre_code` × (`main_div_code` + 2) master cycles. Code 0 gives the smallest ratio (2) and code 1023 the largest (1025).
- R4: With `main_div_skip`=1, the main output period is 2^`main_pre_code` master cycles, and `main_div_code` has no effect.
- R5: At every ratio above 1, each output is high for exactly half its period, measured in half master cycles. This holds for odd ratios too.
- R6: A changed setting is taken up only at the end of the running output period. After a change, no high or low phase is shorter than the shorter of the old and new half periods.
- R7: While `rst_n` is low, both outputs are held low.
- R8: At an overall ratio of 1, the output follows the master clock level directly, in both halves of each master cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pre_code | input | PRE_W | Reference prescale code; ratio 2^code |
| ref_from_pre | input | 1 | 1: reference from its prescaler, 0: master clock |
| main_pre_code | input | PRE_W | Main prescale code; ratio 2^code |
| main_div_code | input | DIV_W | Main integer divider code; ratio code+2 |
| main_div_skip | input | 1 | 1: skip the integer divider |
| ref_clk_o | output | 1 | Reference clock level |
| main_clk_o | output | 1 | Main clock level |

## Verification
The outputs are sampled twice per master cycle. High and low widths are measured in half cycles and compared with the arithmetic period. Dividing by 1 tells a real passthrough apart from a counted clock. The sweep over integer codes 0 to 63 mixes odd and even ratios, which exposes any duty error from the half-cycle stretch. The extreme code 1023, combined with each prescaler, checks the counter width and the product of the two stages. Setting changes made in the middle of a period check that every phase around the switch stays at least as wide as the shorter half period. Repeating a skip-mode measurement after rewriting the integer code shows that the code is ignored.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

   // where the reference output takes its clock from
   typedef enum logic {
      REF_FROM_MASTER   = 1'b0,
      REF_FROM_PRESCALE = 1'b1
   } ref_src_e;

   // bits needed for the largest period: (2^div_w + 1) * 2^(2^pre_w - 1)
   function automatic int unsigned per_width(input int unsigned div_w,
                                             input int unsigned pre_w);
      return div_w + 1 + (1 << pre_w) - 1;
   endfunction

endpackage

// File: rtl/pcd_period_calc.sv
module pcd_period_calc #(
   parameter int unsigned DIV_W   = 10,
   parameter int unsigned PRE_W   = 2,
   parameter int unsigned PER_W   = 14,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic [PRE_W-1:0] pre_code,
   input  logic [DIV_W-1:0] div_code,
   input  logic             div_skip,
   input  logic             force_unit,
   output logic [PER_W-1:0] per_o
);

   logic [PER_W-1:0] pre_ratio;
   logic [PER_W-1:0] chain_per;

   always_comb pre_ratio = PER_W'(1) << pre_code;

   generate
      if (HAS_DIV) begin : g_div
         logic [DIV_W:0] div_ratio;
         always_comb begin
            div_ratio = (DIV_W+1)'(div_code) + (DIV_W+1)'(2);
            chain_per = div_skip ? pre_ratio : (PER_W'(div_ratio) << pre_code);
         end
      end else begin : g_nodiv
         logic unused_ok;
         assign unused_ok = ^{div_code, div_skip};
         always_comb chain_per = pre_ratio;
      end
   endgenerate

   always_comb per_o = force_unit ? PER_W'(1) : chain_per;

   always_comb begin
      assert (per_o != '0) else $error("a_r3_nonzero_period");  // R3
   end

endmodule

// File: rtl/pcd_div_core.sv
module pcd_div_core #(
   parameter int unsigned PER_W   = 14,
   parameter bit          ODD_EXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PER_W-1:0] per_i,
   output logic             clk_o
);

   initial begin
      assert (PER_W >= 2) else $error("PER_W must be at least 2");
   end

   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] cnt_q;
   logic             lvl_q;
   logic             raw_q;
   logic             term;
   logic             shaped;

   assign term = (cnt_q == per_q - PER_W'(1));

   // new period is only taken at the terminal count of the old one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= PER_W'(1);
         cnt_q <= '0;
         lvl_q <= 1'b0;
         raw_q <= 1'b0;
      end else if (term) begin
         per_q <= per_i;
         cnt_q <= '0;
         lvl_q <= (per_i >= PER_W'(2));
         raw_q <= (per_i == PER_W'(1));
      end else begin
         cnt_q <= cnt_q + PER_W'(1);
         lvl_q <= (cnt_q + PER_W'(1)) < (per_q >> 1);
      end
   end

   generate
      if (ODD_EXT) begin : g_odd
         logic ext_q;
         // half-cycle stretch of the high phase for odd periods
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) ext_q <= 1'b0;
            else        ext_q <= lvl_q & per_q[0];
         end
         assign shaped = lvl_q | ext_q;
      end else begin : g_even
         assign shaped = lvl_q;
      end
   endgenerate

   assign clk_o = raw_q ? clk : shaped;

   a_r6_load_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q != $past(per_q)) |-> ($past(cnt_q) == $past(per_q) - PER_W'(1)));

   a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < per_q);

   a_r5_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_q) |-> (cnt_q == '0));

   a_r8_raw_only_unity: assert property (@(posedge clk) disable iff (!rst_n)
      raw_q |-> (per_q == PER_W'(1)));

endmodule

// File: rtl/pcd_clock_chain.sv
module pcd_clock_chain #(
   parameter int unsigned DIV_W = 10,
   parameter int unsigned PRE_W = 2
) (
   input  logic             clk_m,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] ref_pre_code,
   input  logic             ref_from_pre,
   input  logic [PRE_W-1:0] main_pre_code,
   input  logic [DIV_W-1:0] main_div_code,
   input  logic             main_div_skip,
   output logic             ref_clk_o,
   output logic             main_clk_o
);

   localparam int unsigned PER_W = pcd_pkg::per_width(DIV_W, PRE_W);

   initial begin
      assert (PRE_W >= 1 && PRE_W <= 3) else $error("PRE_W out of range");
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("DIV_W out of range");
   end

   pcd_pkg::ref_src_e ref_src;
   logic [PER_W-1:0]  ref_per;
   logic [PER_W-1:0]  main_per;

   assign ref_src = pcd_pkg::ref_src_e'(ref_from_pre);

   pcd_period_calc #(.DIV_W(DIV_W), .PRE_W(PRE_W), .PER_W(PER_W), .HAS_DIV(1'b0)) u_ref_calc (
      .pre_code   (ref_pre_code),
      .div_code   ('0),
      .div_skip   (1'b1),
      .force_unit (ref_src == pcd_pkg::REF_FROM_MASTER),
      .per_o      (ref_per)
   );

   pcd_period_calc #(.DIV_W(DIV_W), .PRE_W(PRE_W), .PER_W(PER_W), .HAS_DIV(1'b1)) u_main_calc (
      .pre_code   (main_pre_code),
      .div_code   (main_div_code),
      .div_skip   (main_div_skip),
      .force_unit (1'b0),
      .per_o      (main_per)
   );

   pcd_div_core #(.PER_W(PER_W), .ODD_EXT(1'b0)) u_ref_core (
      .clk   (clk_m),
      .rst_n (rst_n),
      .per_i (ref_per),
      .clk_o (ref_clk_o)
   );

   pcd_div_core #(.PER_W(PER_W), .ODD_EXT(1'b1)) u_main_core (
      .clk   (clk_m),
      .rst_n (rst_n),
      .per_i (main_per),
      .clk_o (main_clk_o)
   );

endmodule

// File: tb/pcd_clock_chain_tb.sv
module pcd_clock_chain_tb;

   localparam int LIM = 40000;

   logic       clk_m = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_pre_code = 2'd0;
   logic       ref_from_pre = 1'b0;
   logic [1:0] main_pre_code = 2'd0;
   logic [9:0] main_div_code = 10'd0;
   logic       main_div_skip = 1'b0;
   logic       ref_clk_o;
   logic       main_clk_o;

   int total = 0;
   int bad = 0;

   always #2 clk_m = ~clk_m;

   pcd_clock_chain u_dut (
      .clk_m(clk_m), .rst_n(rst_n),
      .ref_pre_code(ref_pre_code), .ref_from_pre(ref_from_pre),
      .main_pre_code(main_pre_code), .main_div_code(main_div_code),
      .main_div_skip(main_div_skip),
      .ref_clk_o(ref_clk_o), .main_clk_o(main_clk_o)
   );

   function automatic logic lvl(input bit m);
      return m ? main_clk_o : ref_clk_o;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // widths of one high and the following low phase, in half master cycles
   task automatic measure(input bit m, output int hi, output int lo);
      int n;
      hi = 0; lo = 0; n = 0;
      while (lvl(m) !== 1'b0 && n < LIM) begin #2; n++; end
      while (lvl(m) !== 1'b1 && n < LIM) begin #2; n++; end
      while (lvl(m) === 1'b1 && n < LIM) begin #2; n++; hi++; end
      while (lvl(m) !== 1'b1 && n < LIM) begin #2; n++; lo++; end
   endtask

   task automatic check_ratio(input bit m, input int t, input string tag);
      int hi, lo;
      measure(m, hi, lo);
      measure(m, hi, lo);
      chk(hi + lo == 2 * t, tag, hi + lo, 2 * t);
      chk(hi == t, {tag, " R5 duty"}, hi, t);
   endtask

   task automatic scan(input bit m, input int nph, input int minw, input string tag);
      logic cur;
      int w, n;
      n = 0;
      cur = lvl(m);
      while (lvl(m) === cur && n < LIM) begin #2; n++; end
      for (int p = 0; p < nph; p++) begin
         cur = lvl(m);
         w = 0;
         while (lvl(m) === cur && n < LIM) begin #2; n++; w++; end
         chk(w >= minw, tag, w, minw);
      end
   endtask

   initial begin
      #760000;
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1;
      // R7: outputs low in reset
      for (int i = 0; i < 6; i++) begin
         chk(ref_clk_o === 1'b0, "R7 ref low in reset", int'(ref_clk_o), 0);
         chk(main_clk_o === 1'b0, "R7 main low in reset", int'(main_clk_o), 0);
         #2;
      end
      rst_n = 1'b1;

      // R2: reference from master clock, prescale code ignored
      ref_from_pre = 1'b0;
      ref_pre_code = 2'd3;
      check_ratio(1'b0, 1, "R2 ref master");
      for (int i = 0; i < 8; i++) begin
         chk(ref_clk_o === clk_m, "R2 ref follows master", int'(ref_clk_o), int'(clk_m));
         #2;
      end

      // R1: reference prescaler sweep
      ref_from_pre = 1'b1;
      for (int c = 0; c < 4; c++) begin
         ref_pre_code = 2'(c);
         check_ratio(1'b0, 1 << c, "R1 ref prescale");
      end

      // R8: main at ratio 1 is the master clock
      main_div_skip = 1'b1;
      main_pre_code = 2'd0;
      check_ratio(1'b1, 1, "R8 main unity");
      for (int i = 0; i < 8; i++) begin
         chk(main_clk_o === clk_m, "R8 main follows master", int'(main_clk_o), int'(clk_m));
         #2;
      end

      // R4: skip mode, prescaler only
      for (int c = 0; c < 4; c++) begin
         main_pre_code = 2'(c);
         check_ratio(1'b1, 1 << c, "R4 skip prescale");
      end
      main_pre_code = 2'd1;
      main_div_code = 10'd0;
      check_ratio(1'b1, 2, "R4 skip code 0");
      main_div_code = 10'd777;
      check_ratio(1'b1, 2, "R4 skip code ignored");

      // R3: integer divider sweep with odd and even ratios
      main_div_skip = 1'b0;
      main_pre_code = 2'd0;
      for (int c = 0; c < 64; c++) begin
         main_div_code = 10'(c);
         check_ratio(1'b1, c + 2, "R3 div sweep");
      end
      for (int p = 1; p < 4; p++) begin
         for (int c = 0; c < 4; c++) begin
            main_pre_code = 2'(p);
            main_div_code = 10'(c);
            check_ratio(1'b1, (c + 2) << p, "R3 prescale times div");
         end
      end
      main_pre_code = 2'd0;
      main_div_code = 10'd1023;
      check_ratio(1'b1, 1025, "R3 max code");
      main_pre_code = 2'd3;
      check_ratio(1'b1, 8200, "R3 max code max prescale");

      // R6: changes mid-period keep every phase wide enough
      main_pre_code = 2'd0;
      main_div_code = 10'd4;
      check_ratio(1'b1, 6, "R6 setup 6");
      #6;
      main_div_code = 10'd1;
      scan(1'b1, 6, 3, "R6 main 6 to 3");
      #10;
      main_div_code = 10'd8;
      scan(1'b1, 6, 3, "R6 main 3 to 10");
      check_ratio(1'b1, 10, "R6 main after change");
      ref_pre_code = 2'd3;
      check_ratio(1'b0, 8, "R6 ref setup 8");
      #6;
      ref_pre_code = 2'd1;
      scan(1'b0, 6, 2, "R6 ref 8 to 2");
      check_ratio(1'b0, 2, "R6 ref after change");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule